// File: doc/BRIEF.md
# Break Entry Sequencer

This block carries out the entry into a software interrupt. A single-cycle start request, taken while the block is idle, captures the current program counter, status word and 8-bit stack pointer. The block then stores the return address and the status word on a stack that grows downward. After that it reads a two-byte vector from fixed high memory and hands back the new program counter, the new status word and the updated stack pointer.

All memory traffic goes through one synchronous byte port: address, write data, write enable and read data. Read data arrives one cycle after its address. The stack sits in a single 256-byte page, and that page is chosen by a parameter. The whole entry takes eight cycles. The cycle in which start is sampled counts as the first, and a one-cycle done pulse marks the last. The surrounding core loads `pc_o`, `psw_o` and `sp_o` in the done cycle.

Top module: `brk_entry_seq`

## Requirements
- R1: After reset, and until a start is accepted, `busy_o`, `done_o` and `mem_we_o` are all 0.
- R2: A start taken while idle captures `pc_i`, `psw_i` and `sp_i`. In the next three cycles the block writes the high PC byte to `{STACK_PAGE, SP}`, then the low PC byte to `{STACK_PAGE, SP-1}`, then the status byte to `{STACK_PAGE, SP-2}`. Inputs that change after the start cycle have no effect.
- R3: The stored status byte equals the captured status word with bit 4 (break flag) forced to 1. All other bits are copied unchanged.
- R4: The stack pointer counts down by one after each of the three writes, modulo 256, so 0x00 is followed by 0xFF. In the done cycle `sp_o` equals the captured SP minus 3, modulo 256.
- R5: In the fourth cycle after the start edge the block drives read address 0xFFDE. In the fifth it drives 0xFFDF. Each byte is taken one cycle after its address. In the done cycle `pc_o` = {byte read from 0xFFDF, byte read from 0xFFDE}.
- R6: In the done cycle `psw_o` holds bit 4 = 1 and bit 2 (interrupt enable) = 0. Bits 7, 6, 5, 3, 1 and 0 equal the captured status word.
- R7: `done_o` is high for exactly one cycle: the seventh cycle after the start edge, which makes eight cycles including the start cycle. `busy_o` is high from the first cycle after the start edge through the done cycle and low in the cycle after it.
- R8: A start that arrives while `busy_o` is high is ignored. The running sequence keeps its captured values and its timing, and no new sequence follows it.
- R9: `mem_we_o` is high only in the three write cycles of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only when idle |
| pc_i | input | 16 | Current program counter |
| psw_i | input | 8 | Current status word |
| sp_i | input | 8 | Current stack pointer |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, one cycle after address |
| pc_o | output | 16 | New program counter, valid with done_o |
| psw_o | output | 8 | New status word, valid with done_o |
| sp_o | output | 8 | New stack pointer, valid with done_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with `STACK_PAGE` = 8'hA5 rather than the default. A wrong or lost page bits in the write address therefore shows up at once. With the 8-bit stack pointer, the bench sweeps every one of the 256 start values, so runs whose three pushes cross 0x00 into 0xFF are all included. The status word steps through all 256 values by an odd-multiplier mapping, so every bit pattern meets the B-set and I-clear rules. On every sixteenth run a start is injected in the middle of the sequence with different inputs.

// File: rtl/brk_pkg.sv
`timescale 1ns/1ps
package brk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PUSH_H = 3'd1,
    ST_PUSH_L = 3'd2,
    ST_PUSH_P = 3'd3,
    ST_VEC_L  = 3'd4,
    ST_VEC_H  = 3'd5,
    ST_LATCH  = 3'd6,
    ST_DONE   = 3'd7
  } brk_state_e;

  localparam int unsigned PSW_B_BIT = 4;
  localparam int unsigned PSW_I_BIT = 2;
endpackage

// File: rtl/brk_ctrl.sv
`timescale 1ns/1ps
module brk_ctrl
  import brk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output brk_state_e state_o,
  output logic       accept_o
);
  brk_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_PUSH_H;
      ST_PUSH_H: state_d = ST_PUSH_L;
      ST_PUSH_L: state_d = ST_PUSH_P;
      ST_PUSH_P: state_d = ST_VEC_L;
      ST_VEC_L:  state_d = ST_VEC_H;
      ST_VEC_H:  state_d = ST_LATCH;
      ST_LATCH:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/brk_stack.sv
`timescale 1ns/1ps
module brk_stack #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16,
  parameter logic [AW-DW-1:0] STACK_PAGE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] sp_i,
  input  logic          dec_i,
  output logic [DW-1:0] sp_o,
  output logic [AW-1:0] addr_o
);
  logic [DW-1:0] sp_q;

  // natural modulo wrap at the page edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (load_i) sp_q <= sp_i;
    else if (dec_i)  sp_q <= sp_q - 1'b1;
  end

  assign sp_o   = sp_q;
  assign addr_o = {STACK_PAGE, sp_q};
endmodule

// File: rtl/brk_vec.sv
`timescale 1ns/1ps
module brk_vec
  import brk_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  brk_state_e      state_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [2*DW-1:0] pc_o
);
  logic [DW-1:0] lo_q, hi_q;

  // read data lags address by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (state_i == ST_VEC_H) lo_q <= rdata_i;
      if (state_i == ST_LATCH) hi_q <= rdata_i;
    end
  end

  assign pc_o = {hi_q, lo_q};
endmodule

// File: rtl/brk_entry_seq.sv
`timescale 1ns/1ps
module brk_entry_seq
  import brk_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16,
  parameter logic [AW-DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFDE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [DW-1:0]   psw_i,
  input  logic [DW-1:0]   sp_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_we_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [2*DW-1:0] pc_o,
  output logic [DW-1:0]   psw_o,
  output logic [DW-1:0]   sp_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam logic [AW-1:0] VEC_ADDR_HI = VEC_ADDR + 1'b1;
  localparam logic [DW-1:0] B_MASK = DW'(1) << PSW_B_BIT;
  localparam logic [DW-1:0] I_MASK = DW'(1) << PSW_I_BIT;

  brk_state_e      state;
  logic            accept;
  logic            push;
  logic [AW-1:0]   stack_addr;
  logic [2*DW-1:0] pc_q;
  logic [DW-1:0]   psw_q;
  logic [DW-1:0]   psw_pushed;

  brk_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state),
    .accept_o(accept)
  );

  assign push = (state == ST_PUSH_H) || (state == ST_PUSH_L) || (state == ST_PUSH_P);

  brk_stack #(.DW(DW), .AW(AW), .STACK_PAGE(STACK_PAGE)) u_stack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .sp_i  (sp_i),
    .dec_i (push),
    .sp_o  (sp_o),
    .addr_o(stack_addr)
  );

  brk_vec #(.DW(DW)) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_i(state),
    .rdata_i(mem_rdata_i),
    .pc_o   (pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      psw_q <= '0;
    end else if (accept) begin
      pc_q  <= pc_i;
      psw_q <= psw_i;
    end
  end

  assign psw_pushed = psw_q | B_MASK;

  always_comb begin
    mem_addr_o  = stack_addr;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    unique case (state)
      ST_PUSH_H: begin mem_we_o = 1'b1; mem_wdata_o = pc_q[2*DW-1:DW]; end
      ST_PUSH_L: begin mem_we_o = 1'b1; mem_wdata_o = pc_q[DW-1:0]; end
      ST_PUSH_P: begin mem_we_o = 1'b1; mem_wdata_o = psw_pushed; end
      ST_VEC_L:  mem_addr_o = VEC_ADDR;
      ST_VEC_H:  mem_addr_o = VEC_ADDR_HI;
      default:   ;
    endcase
  end

  assign psw_o  = psw_pushed & ~I_MASK;
  assign busy_o = (state != ST_IDLE);
  assign done_o = (state == ST_DONE);
endmodule

// File: rtl/brk_chk.sv
`timescale 1ns/1ps
module brk_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16,
  parameter logic [AW-DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFDE
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [DW-1:0] sp_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_we_o,
  input logic [DW-1:0] psw_o,
  input logic          busy_o,
  input logic          done_o
);
  a_r2_first_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (mem_we_o && mem_addr_o == {STACK_PAGE, $past(sp_i)}));

  a_r9_write_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[AW-1:DW] == STACK_PAGE && busy_o));

  a_r6_flags_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (psw_o[4] && !psw_o[2]));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  a_r7_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r5_vec_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_addr_o == VEC_ADDR) |-> !mem_we_o);

  a_r8_busy_start_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind brk_entry_seq brk_chk #(
  .DW(DW), .AW(AW), .STACK_PAGE(STACK_PAGE), .VEC_ADDR(VEC_ADDR)
) u_chk (.*);

// File: tb/sim_brk_entry_seq.sv
`timescale 1ns/1ps
module sim_brk_entry_seq;
  localparam logic [7:0] PAGE = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  psw_in = '0;
  logic [7:0]  sp_in = '0;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        we;
  logic [7:0]  rdata;
  logic [15:0] pc_out;
  logic [7:0]  psw_out;
  logic [7:0]  sp_out;
  logic        busy;
  logic        done;

  logic [7:0] vec_lo = '0;
  logic [7:0] vec_hi = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  brk_entry_seq #(.STACK_PAGE(PAGE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pc_i(pc_in), .psw_i(psw_in), .sp_i(sp_in),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_rdata_i(rdata),
    .pc_o(pc_out), .psw_o(psw_out), .sp_o(sp_out),
    .busy_o(busy), .done_o(done)
  );

  // synchronous read memory model: one cycle latency
  always_ff @(posedge clk) begin
    if (addr == 16'hFFDE)      rdata <= vec_lo;
    else if (addr == 16'hFFDF) rdata <= vec_hi;
    else                       rdata <= 8'h5A;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] pc, input logic [7:0] psw, input logic [7:0] sp,
                     input logic [7:0] vl, input logic [7:0] vh, input bit inject);
    logic [7:0] pushed;
    pushed = psw | 8'h10;
    vec_lo = vl;
    vec_hi = vh;
    @(negedge clk);
    start = 1'b1; pc_in = pc; psw_in = psw; sp_in = sp;
    @(negedge clk); // cycle 1
    start = 1'b0; pc_in = ~pc; psw_in = ~psw; sp_in = sp + 8'd77;
    chk("R2 pch we", {31'd0, we}, 32'd1);
    chk("R2 pch addr", {16'd0, addr}, {16'd0, PAGE, sp});
    chk("R2 pch data", {24'd0, wdata}, {24'd0, pc[15:8]});
    chk("R7 busy c1", {31'd0, busy}, 32'd1);
    @(negedge clk); // cycle 2
    chk("R2 pcl addr", {16'd0, addr}, {16'd0, PAGE, 8'(sp - 8'd1)});
    chk("R2 pcl data", {23'd0, we, wdata}, {23'd0, 1'b1, pc[7:0]});
    @(negedge clk); // cycle 3
    chk("R4 psw addr", {16'd0, addr}, {16'd0, PAGE, 8'(sp - 8'd2)});
    chk("R3 psw data", {23'd0, we, wdata}, {23'd0, 1'b1, pushed});
    @(negedge clk); // cycle 4
    if (inject) begin
      start = 1'b1; pc_in = 16'h1234; psw_in = 8'h04; sp_in = 8'h10;
    end
    chk("R5 vec lo addr", {15'd0, we, addr}, {15'd0, 1'b0, 16'hFFDE});
    @(negedge clk); // cycle 5
    start = 1'b0;
    chk("R5 vec hi addr", {15'd0, we, addr}, {15'd0, 1'b0, 16'hFFDF});
    @(negedge clk); // cycle 6
    chk("R9 no we c6", {30'd0, we, done}, 32'd0);
    @(negedge clk); // cycle 7
    chk("R7 done", {30'd0, done, busy}, 32'd3);
    chk("R5 pc", {16'd0, pc_out}, {16'd0, vh, vl});
    chk("R6 psw", {24'd0, psw_out}, {24'd0, pushed & 8'hFB});
    chk("R4 sp", {24'd0, sp_out}, {24'd0, 8'(sp - 8'd3)});
    @(negedge clk); // after
    chk(inject ? "R8 no restart" : "R7 end", {29'd0, done, busy, we}, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #35;
    // R1 reset state
    chk("R1 reset", {29'd0, busy, done, we}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle", {29'd0, busy, done, we}, 32'd0);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] s;
      s = 8'(i);
      run({s ^ 8'hC3, ~s}, 8'(s * 8'd37) ^ 8'h5C, s, s + 8'd1, s ^ 8'h9E, (i % 16) == 5);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule